// File: doc/BRIEF.md
# Burst Write Scheduler for Double-Data-Rate Memory

This block collects write traffic from user logic in four independent queues and turns it into burst write commands for a double-data-rate memory controller. The queues hold start addresses, rising-lane data words, falling-lane data words and byte-mask bytes. User logic writes all three data queues from one shared wide bus, and a separate write strobe for each queue selects its slice. Each queued address claims two words from each data lane and two mask bytes. Together these make one four-word burst with per-byte write enables.

The scheduler keeps track of one open row. A burst whose row matches the open row is written at once. A burst to another row first closes the open row and then opens the new one. When no complete burst is waiting, the open row is closed. Consecutive queued bursts within one row therefore merge into one long transfer without reopening the row. Commands leave through a simple valid/acknowledge port that stands in for the memory controller.

A wrapping access counter counts completed burst writes up and reported burst reads down. It can be cleared asynchronously.

Top module: `burst_wr_sched`

## Requirements
- R1: The 72-bit `wr_bus` is shared by the data queues. Bits 71:40 go to the falling queue, bits 39:8 to the rising queue and bits 7:0 to the mask queue. The address queue takes `addr_in`. Each high cycle of a queue's write strobe stores exactly one entry in that queue only.
- R2: A queue raises its bit of `q_full` when it holds Q_DEPTH entries. A write to a full queue is dropped and leaves the queue contents unchanged. Flag bit order is 0 address, 1 rising, 2 falling, 3 mask.
- R3: A queue raises its bit of `q_afull` once it holds Q_DEPTH-1 or more entries. From Q_DEPTH-1 entries, exactly one further write is accepted and the queue then reports full.
- R4: A burst write is launched only when the address queue holds an entry and the rising, falling and mask queues each hold at least two. Each launched burst removes one address and two entries from each of the other queues. With an incomplete burst and no open row, no command is issued.
- R5: A write command (`cmd_op` = 3) carries the popped address on `cmd_addr`. `cmd_data` holds, from bits 31:0 upward, the first rising word, the first falling word, the second rising word and the second falling word.
- R6: `cmd_be` bit 4k+b set means byte b of word k is written. The first mask byte covers words 0 and 1, and the second covers words 2 and 3. Within a mask byte, bits 7:4 control the rising word's bytes 3:0 and bits 3:0 control the falling word's bytes 3:0. A mask bit of 0 enables the byte and a mask bit of 1 suppresses it.
- R7: The row is address bits 24:10. With no row open, a burst is preceded by an open command (`cmd_op` = 2) whose `cmd_addr` is the row with bits 9:0 zero. A burst to the open row is issued directly, with no open or close command.
- R8: When a burst targets a row other than the open one, the scheduler first issues a close command (`cmd_op` = 1), then an open command, then the write.
- R9: When the command port is free, a row is open and no complete burst is waiting, a close command is issued. Its `cmd_addr` is the open row with bits 9:0 zero.
- R10: A command stays on `cmd_valid`, `cmd_op`, `cmd_addr`, `cmd_data` and `cmd_be` without change until a cycle with `cmd_ack` high, which completes it.
- R11: `access_cnt` increments on every completed write command and decrements on every cycle with `rd_done` high. It is unchanged when both happen in the same cycle, and it wraps in both directions.
- R12: `cnt_clr` clears `access_cnt` at once, without waiting for a clock edge. The synchronous `rst` empties all queues, lowers all flags and `cmd_valid`, closes the row and zeroes the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clr | input | 1 | Asynchronous clear of the access counter |
| wr_bus | input | 72 | Shared data bus for the rising, falling and mask queues |
| addr_in | input | 25 | Burst start address for the address queue |
| we_addr | input | 1 | Address queue write strobe |
| we_rise | input | 1 | Rising queue write strobe |
| we_fall | input | 1 | Falling queue write strobe |
| we_mask | input | 1 | Mask queue write strobe |
| q_full | output | 4 | Full flags (0 address, 1 rising, 2 falling, 3 mask) |
| q_afull | output | 4 | Almost-full flags, same order |
| cmd_valid | output | 1 | Command pending |
| cmd_op | output | 2 | 1 close row, 2 open row, 3 burst write |
| cmd_addr | output | 25 | Row (open/close) or burst start address |
| cmd_data | output | 128 | Four burst words, word 0 in bits 31:0 |
| cmd_be | output | 16 | Byte enables, bit 4k+b for word k byte b |
| cmd_ack | input | 1 | Controller accepts the pending command |
| rd_done | input | 1 | One four-word read access completed |
| access_cnt | output | 32 | Wrapping access counter |

## Verification
The bench builds the block with a queue depth of 4 and leaves all other parameters at their defaults. With that depth, two bursts fill both data queues exactly, so a same-row merge and a row change can each be staged while the controller holds off acknowledge. The depth also makes the full and almost-full flags, and a dropped write, reachable within a few strobes. The counter's wrap in both directions is driven through read reports around an asynchronous clear.

// File: rtl/burst_wr_pkg.sv
package burst_wr_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_PRE = 2'd1,
    OP_ACT = 2'd2,
    OP_WR  = 2'd3
  } mem_op_e;

  localparam int Q_ADDR = 0;
  localparam int Q_RISE = 1;
  localparam int Q_FALL = 2;
  localparam int Q_MASK = 3;
  localparam int Q_NUM  = 4;
endpackage

// File: rtl/bwq_fifo.sv
// Show-ahead queue; DEPTH must be a power of two. RD_N heads are visible
// and up to RD_N entries can be removed per cycle.
module bwq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int RD_N  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic [1:0]                 pop_n,
  output logic [RD_N*W-1:0]          heads,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       afull
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] lvl_d;
  logic          push_ok;

  assign push_ok = push && !full;
  assign lvl_d   = level + CW'(push_ok) - CW'(pop_n);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      full  <= 1'b0;
      afull <= 1'b0;
    end else begin
      wp    <= wp + AW'(push_ok);
      rp    <= rp + AW'(pop_n);
      level <= lvl_d;
      full  <= (lvl_d == CW'(DEPTH));
      afull <= (lvl_d >= CW'(DEPTH-1));
    end
  end

  for (genvar g = 0; g < RD_N; g++) begin : g_head
    logic [AW-1:0] rp_g;
    assign rp_g = rp + AW'(g);
    assign heads[g*W +: W] = mem[rp_g];
  end

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && pop_n == 2'd0) |=> (full && $stable(level)));

  // R3
  afull_last_chk: assert property (@(posedge clk) disable iff (rst)
    (afull && !full && push && pop_n == 2'd0) |=> full);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    CW'(pop_n) <= level);
endmodule

// File: rtl/bwr_lane_map.sv
// Assembles the four burst words and byte enables from two beats of
// rising/falling words and mask bytes.
module bwr_lane_map #(
  parameter int WORD_W = 32
) (
  input  logic [2*WORD_W-1:0]   rise_pair,
  input  logic [2*WORD_W-1:0]   fall_pair,
  input  logic [2*WORD_W/4-1:0] mask_pair,
  output logic [4*WORD_W-1:0]   data,
  output logic [4*WORD_W/8-1:0] be
);
  localparam int LB = WORD_W / 8;

  for (genvar g = 0; g < 2; g++) begin : g_beat
    logic [2*LB-1:0] mbyte;
    assign mbyte = mask_pair[g*2*LB +: 2*LB];
    assign data[(2*g)*WORD_W   +: WORD_W] = rise_pair[g*WORD_W +: WORD_W];
    assign data[(2*g+1)*WORD_W +: WORD_W] = fall_pair[g*WORD_W +: WORD_W];
    // mask bit 1 suppresses; upper half belongs to the rising word
    assign be[(2*g)*LB   +: LB] = ~mbyte[LB +: LB];
    assign be[(2*g+1)*LB +: LB] = ~mbyte[0  +: LB];
  end
endmodule

// File: rtl/bwr_access_cnt.sv
module bwr_access_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);
  logic clr_mark;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      cnt <= '0;
    end else if (rst) begin
      cnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // records a clear seen since the previous edge
  always_ff @(posedge clk or posedge clr) begin
    if (clr) clr_mark <= 1'b1;
    else     clr_mark <= 1'b0;
  end

  // R11
  cnt_up_chk: assert property (@(posedge clk) disable iff (rst || clr_mark)
    (inc && !dec) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R11
  cnt_down_chk: assert property (@(posedge clk) disable iff (rst || clr_mark)
    (dec && !inc) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/burst_wr_sched.sv
module burst_wr_sched
  import burst_wr_pkg::*;
#(
  parameter int ADDR_W  = 25,
  parameter int ROW_W   = 15,
  parameter int WORD_W  = 32,
  parameter int Q_DEPTH = 16,
  parameter int CNT_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cnt_clr,
  input  logic [2*WORD_W+WORD_W/4-1:0] wr_bus,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic                     we_addr,
  input  logic                     we_rise,
  input  logic                     we_fall,
  input  logic                     we_mask,
  output logic [3:0]               q_full,
  output logic [3:0]               q_afull,
  output logic                     cmd_valid,
  output logic [1:0]               cmd_op,
  output logic [ADDR_W-1:0]        cmd_addr,
  output logic [4*WORD_W-1:0]      cmd_data,
  output logic [WORD_W/2-1:0]      cmd_be,
  input  logic                     cmd_ack,
  input  logic                     rd_done,
  output logic [CNT_W-1:0]         access_cnt
);
  localparam int MASK_W  = WORD_W / 4;
  localparam int ROW_LSB = ADDR_W - ROW_W;
  localparam int QCW     = $clog2(Q_DEPTH + 1);
  localparam int RISE_LO = MASK_W;
  localparam int FALL_LO = MASK_W + WORD_W;

  // queue outputs
  logic [ADDR_W-1:0]   a_head;
  logic [2*WORD_W-1:0] r_heads, f_heads;
  logic [2*MASK_W-1:0] m_heads;
  logic [QCW-1:0]      a_lvl, r_lvl, f_lvl, m_lvl;
  logic [Q_NUM-1:0]    full_v, afull_v;

  // scheduler state
  logic              cmd_valid_q;
  mem_op_e           cmd_op_q;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic [4*WORD_W-1:0] cmd_data_q;
  logic [WORD_W/2-1:0] cmd_be_q;
  logic              row_open;
  logic [ROW_W-1:0]  open_row;

  logic                launch_wr, launch_act, launch_pre;
  logic                burst_rdy, row_hit;
  logic [ROW_W-1:0]    head_row;
  logic [4*WORD_W-1:0] lane_data;
  logic [WORD_W/2-1:0] lane_be;
  logic [1:0]          data_pop;
  logic                wr_done;

  bwq_fifo #(.W(ADDR_W), .DEPTH(Q_DEPTH), .RD_N(1)) u_q_addr (
    .clk(clk), .rst(rst), .push(we_addr), .din(addr_in),
    .pop_n({1'b0, launch_wr}), .heads(a_head), .level(a_lvl),
    .full(full_v[Q_ADDR]), .afull(afull_v[Q_ADDR]));

  bwq_fifo #(.W(WORD_W), .DEPTH(Q_DEPTH), .RD_N(2)) u_q_rise (
    .clk(clk), .rst(rst), .push(we_rise), .din(wr_bus[RISE_LO +: WORD_W]),
    .pop_n(data_pop), .heads(r_heads), .level(r_lvl),
    .full(full_v[Q_RISE]), .afull(afull_v[Q_RISE]));

  bwq_fifo #(.W(WORD_W), .DEPTH(Q_DEPTH), .RD_N(2)) u_q_fall (
    .clk(clk), .rst(rst), .push(we_fall), .din(wr_bus[FALL_LO +: WORD_W]),
    .pop_n(data_pop), .heads(f_heads), .level(f_lvl),
    .full(full_v[Q_FALL]), .afull(afull_v[Q_FALL]));

  bwq_fifo #(.W(MASK_W), .DEPTH(Q_DEPTH), .RD_N(2)) u_q_mask (
    .clk(clk), .rst(rst), .push(we_mask), .din(wr_bus[MASK_W-1:0]),
    .pop_n(data_pop), .heads(m_heads), .level(m_lvl),
    .full(full_v[Q_MASK]), .afull(afull_v[Q_MASK]));

  bwr_lane_map #(.WORD_W(WORD_W)) u_lane (
    .rise_pair(r_heads), .fall_pair(f_heads), .mask_pair(m_heads),
    .data(lane_data), .be(lane_be));

  // burst readiness and row compare
  assign burst_rdy = (a_lvl != '0) && (r_lvl >= QCW'(2)) &&
                     (f_lvl >= QCW'(2)) && (m_lvl >= QCW'(2));
  assign head_row  = a_head[ROW_LSB +: ROW_W];
  assign row_hit   = row_open && (head_row == open_row);

  assign launch_wr  = !cmd_valid_q && burst_rdy && row_hit;
  assign launch_act = !cmd_valid_q && burst_rdy && !row_open;
  assign launch_pre = !cmd_valid_q && row_open && !(burst_rdy && row_hit);
  assign data_pop   = launch_wr ? 2'd2 : 2'd0;
  assign wr_done    = cmd_valid_q && cmd_ack && (cmd_op_q == OP_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid_q <= 1'b0;
      cmd_op_q    <= OP_NOP;
      cmd_addr_q  <= '0;
      cmd_data_q  <= '0;
      cmd_be_q    <= '0;
      row_open    <= 1'b0;
      open_row    <= '0;
    end else if (cmd_valid_q) begin
      if (cmd_ack) begin
        cmd_valid_q <= 1'b0;
        case (cmd_op_q)
          OP_ACT: begin
            row_open <= 1'b1;
            open_row <= cmd_addr_q[ROW_LSB +: ROW_W];
          end
          OP_PRE:  row_open <= 1'b0;
          default: ;
        endcase
      end
    end else if (launch_wr) begin
      cmd_valid_q <= 1'b1;
      cmd_op_q    <= OP_WR;
      cmd_addr_q  <= a_head;
      cmd_data_q  <= lane_data;
      cmd_be_q    <= lane_be;
    end else if (launch_act) begin
      cmd_valid_q <= 1'b1;
      cmd_op_q    <= OP_ACT;
      cmd_addr_q  <= {head_row, {ROW_LSB{1'b0}}};
    end else if (launch_pre) begin
      cmd_valid_q <= 1'b1;
      cmd_op_q    <= OP_PRE;
      cmd_addr_q  <= {open_row, {ROW_LSB{1'b0}}};
    end
  end

  bwr_access_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr),
    .inc(wr_done), .dec(rd_done), .cnt(access_cnt));

  assign q_full    = full_v;
  assign q_afull   = afull_v;
  assign cmd_valid = cmd_valid_q;
  assign cmd_op    = cmd_op_q;
  assign cmd_addr  = cmd_addr_q;
  assign cmd_data  = cmd_data_q;
  assign cmd_be    = cmd_be_q;

  // R7
  wr_open_row_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd3) |->
      (row_open && cmd_addr[ROW_LSB +: ROW_W] == open_row));

  // R8
  act_when_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2) |-> !row_open);

  // R9
  pre_when_open_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1) |-> row_open);

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ack) |=>
      (cmd_valid && $stable(cmd_op) && $stable(cmd_addr) &&
       $stable(cmd_data) && $stable(cmd_be)));
endmodule

// File: tb/burst_wr_sched_tb.sv
module burst_wr_sched_tb_top;
  localparam logic [1:0] E_PRE = 2'd1;
  localparam logic [1:0] E_ACT = 2'd2;
  localparam logic [1:0] E_WR  = 2'd3;
  localparam int N_EXP = 14;

  // {op, cmd_addr, burst index}
  localparam logic [30:0] EXP_TBL [N_EXP] = '{
    {E_ACT, 25'h1400, 4'd0}, {E_WR, 25'h1400, 4'd0}, {E_WR, 25'h1404, 4'd1},
    {E_PRE, 25'h1400, 4'd0}, {E_ACT, 25'h1C00, 4'd0}, {E_WR, 25'h1C00, 4'd2},
    {E_PRE, 25'h1C00, 4'd0}, {E_ACT, 25'h2000, 4'd0}, {E_WR, 25'h2000, 4'd3},
    {E_PRE, 25'h2000, 4'd0}, {E_ACT, 25'h0C00, 4'd0}, {E_WR, 25'h0C00, 4'd4},
    {E_WR, 25'h0C04, 4'd5},  {E_PRE, 25'h0C00, 4'd0}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst = 1'b1, cnt_clr = 1'b0;
  logic [71:0]  wr_bus = '0;
  logic [24:0]  addr_in = '0;
  logic         we_addr = 0, we_rise = 0, we_fall = 0, we_mask = 0;
  logic [3:0]   q_full, q_afull;
  logic         cmd_valid;
  logic [1:0]   cmd_op;
  logic [24:0]  cmd_addr;
  logic [127:0] cmd_data;
  logic [15:0]  cmd_be;
  logic         cmd_ack = 1'b0, rd_done = 1'b0;
  logic [31:0]  access_cnt;

  burst_wr_sched #(.Q_DEPTH(4)) dut_i (
    .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .wr_bus(wr_bus),
    .addr_in(addr_in), .we_addr(we_addr), .we_rise(we_rise),
    .we_fall(we_fall), .we_mask(we_mask), .q_full(q_full),
    .q_afull(q_afull), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_be(cmd_be),
    .cmd_ack(cmd_ack), .rd_done(rd_done), .access_cnt(access_cnt));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [1:0]   lg_op   [32];
  logic [24:0]  lg_addr [32];
  logic [127:0] lg_data [32];
  logic [15:0]  lg_be   [32];
  int lg_n = 0;

  // record every accepted command, sampled away from the rising edge
  always @(negedge clk) begin
    #1;
    if (cmd_valid && cmd_ack && lg_n < 32) begin
      lg_op[lg_n]   = cmd_op;
      lg_addr[lg_n] = cmd_addr;
      lg_data[lg_n] = cmd_data;
      lg_be[lg_n]   = cmd_be;
      lg_n++;
    end
  end

  function automatic logic [31:0] rw(int i, int j);
    return 32'h1000_0000 | 32'(i << 8) | 32'(j);
  endfunction
  function automatic logic [31:0] fw(int i, int j);
    return 32'h2000_0000 | 32'(i << 12) | 32'(j + 7);
  endfunction
  function automatic logic [7:0] mk(int i, int j);
    return 8'(8'hC5 ^ (i * 16 + j * 3));
  endfunction
  function automatic logic [127:0] exp_data(int i);
    return {fw(i, 1), rw(i, 1), fw(i, 0), rw(i, 0)};
  endfunction
  function automatic logic [15:0] exp_be(int i);
    logic [7:0] m0, m1;
    m0 = mk(i, 0);
    m1 = mk(i, 1);
    return {~m1[3:0], ~m1[7:4], ~m0[3:0], ~m0[7:4]};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_one(input int q, input logic [31:0] v, input logic [24:0] a);
    @(negedge clk);
    case (q)
      0: begin addr_in = a; we_addr = 1'b1; end
      1: begin wr_bus = {32'hFFFF_FFFF, v, 8'hFF}; we_rise = 1'b1; end
      2: begin wr_bus = {v, 32'hFFFF_FFFF, 8'hFF}; we_fall = 1'b1; end
      default: begin wr_bus = {64'hFFFF_FFFF_FFFF_FFFF, v[7:0]}; we_mask = 1'b1; end
    endcase
    @(negedge clk);
    we_addr = 1'b0; we_rise = 1'b0; we_fall = 1'b0; we_mask = 1'b0;
  endtask

  task automatic push_burst(input int i, input logic [24:0] a);
    wr_one(1, rw(i, 0), '0);
    wr_one(2, fw(i, 0), '0);
    wr_one(3, {24'h0, mk(i, 0)}, '0);
    wr_one(1, rw(i, 1), '0);
    wr_one(2, fw(i, 1), '0);
    wr_one(3, {24'h0, mk(i, 1)}, '0);
    wr_one(0, '0, a);
  endtask

  task automatic rd_pulse();
    @(negedge clk); rd_done = 1'b1;
    @(negedge clk); rd_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R12 reset state
    chk("R12 reset cmd_valid", 128'(cmd_valid), 128'd0);
    chk("R12 reset full", 128'(q_full), 128'd0);
    chk("R12 reset afull", 128'(q_afull), 128'd0);
    chk("R12 reset count", 128'(access_cnt), 128'd0);
    rst = 1'b0;
    @(negedge clk);

    // Scenario A: two bursts in row 5, merged
    push_burst(0, 25'h1400);
    push_burst(1, 25'h1404);
    chk("R7 open pending", 128'(cmd_op), 128'(E_ACT));
    chk("R10 stalled valid", 128'(cmd_valid), 128'd1);
    repeat (3) @(negedge clk);
    chk("R10 stalled addr", 128'(cmd_addr), 128'h1400);
    chk("R2 data queues full", 128'(q_full), 128'b1110);
    cmd_ack = 1'b1;
    repeat (20) @(negedge clk);

    // Scenario B: row change between two bursts
    cmd_ack = 1'b0;
    push_burst(2, 25'h1C00);
    push_burst(3, 25'h2000);
    cmd_ack = 1'b1;
    repeat (25) @(negedge clk);
    chk("R11 count after four writes", 128'(access_cnt), 128'd4);

    // R11 wrap downward
    for (int k = 0; k < 5; k++) rd_pulse();
    chk("R11 wrap below zero", 128'(access_cnt), 128'hFFFF_FFFF);

    // R12 asynchronous clear, checked before any clock edge
    @(negedge clk);
    cnt_clr = 1'b1;
    #1;
    chk("R12 async clear", 128'(access_cnt), 128'd0);
    #1;
    cnt_clr = 1'b0;
    rd_pulse();
    chk("R11 decrement from zero", 128'(access_cnt), 128'hFFFF_FFFF);

    // Scenario C: flags and a dropped write on the rising queue
    wr_one(1, rw(4, 0), '0);
    wr_one(1, rw(4, 1), '0);
    chk("R3 afull below threshold", 128'(q_afull[1]), 128'd0);
    wr_one(1, rw(5, 0), '0);
    chk("R3 afull at depth-1", 128'(q_afull[1]), 128'd1);
    chk("R3 not yet full", 128'(q_full[1]), 128'd0);
    wr_one(1, rw(5, 1), '0);
    chk("R3 one more write fills", 128'(q_full[1]), 128'd1);
    wr_one(1, 32'hDEAD_BEEF, '0);
    chk("R2 full stays after dropped write", 128'(q_full[1]), 128'd1);
    chk("R1 strobe touches only rising queue", 128'(q_full), 128'b0010);
    wr_one(2, fw(4, 0), '0);
    wr_one(2, fw(4, 1), '0);
    wr_one(2, fw(5, 0), '0);
    wr_one(2, fw(5, 1), '0);
    wr_one(3, {24'h0, mk(4, 0)}, '0);
    wr_one(3, {24'h0, mk(4, 1)}, '0);
    wr_one(3, {24'h0, mk(5, 0)}, '0);
    wr_one(3, {24'h0, mk(5, 1)}, '0);
    repeat (3) @(negedge clk);
    chk("R4 no command without address", 128'(cmd_valid), 128'd0);
    cmd_ack = 1'b0;
    wr_one(0, '0, 25'h0C00);
    wr_one(0, '0, 25'h0C04);
    cmd_ack = 1'b1;
    repeat (20) @(negedge clk);
    chk("R11 wrap above all ones", 128'(access_cnt), 128'd1);
    chk("R2 dropped word left no entry", 128'(q_afull), 128'd0);
    chk("R4 idle after queues drain", 128'(cmd_valid), 128'd0);

    // command log against the expected table
    chk("R7 R8 R9 command count", 128'(lg_n), 128'(N_EXP));
    for (int e = 0; e < N_EXP; e++) begin
      logic [30:0] ent;
      ent = EXP_TBL[e];
      chk("R7 R8 R9 op order", 128'(lg_op[e]), 128'(ent[30:29]));
      chk("R5 R7 command address", 128'(lg_addr[e]), 128'(ent[28:4]));
      if (ent[30:29] == E_WR) begin
        chk("R1 R5 burst words", lg_data[e], exp_data(int'(ent[3:0])));
        chk("R6 byte enables", 128'(lg_be[e]), 128'(exp_be(int'(ent[3:0]))));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule